// File: doc/BRIEF.md
# Keyed Non-Volatile Configuration Sequencer

This block sits beside a register file that a serial-bus slave drives, and owns a small non-volatile image of twelve configuration bytes. When reset is released it reads the whole image from the array into the working registers at addresses 0x20 to 0x2B. It does the same on a wake pulse, unless the host has taken ownership of the register values. While it is idle, the host can read and write those registers freely.

To store the registers back into the array, the host follows a fixed order. It sets the host-data select bit, writes the configuration bytes, writes the unlock key and then sets the start bit. The block copies the twelve bytes one at a time to the array in ascending order, waiting on the array's busy flag for each byte. It then holds a programming window timed by a counter and clears the start bit by itself. A start request that lacks the key, the select bit or an adequate supply is refused and sets a sticky error flag. Every attempt, whether it succeeds or not, clears the key.

Register map: config bytes 0x20..0x2B; control 0x60 (bit0 host-data select); key 0x61; command/status 0x62 (bit0 start, reads 1 while programming; bit1 busy, read-only; bit2 error, write 1 to clear).

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset release the block reads array bytes 0..11 into registers 0x20..0x2B. Status bit1 (busy) reads 1 until that load is complete.
- R2: A one-cycle wake pulse while idle with control bit0 = 0 reloads all twelve registers from the array. With control bit0 = 1, a wake pulse starts no load and leaves the register values as the host wrote them.
- R3: While idle, a host write to any address in 0x20..0x2B updates that byte, and a read returns it one cycle after the read strobe.
- R4: A start request (write of 1 to 0x62 bit0 while idle) that is accepted writes register 0x20+i to array index i for i = 0..11 in ascending order, each byte once.
- R5: Status reads 0x03 (start and busy) while programming. Both bits return to 0 by themselves after the last byte is accepted and PROG_TICKS further cycles have passed.
- R6: A start request is refused if the key register does not hold 0xB6 or control bit0 is 0. A refused request writes nothing to the array and sets status bit2.
- R7: A start request made while the supply-adequate input is low is refused in the same way as in R6.
- R8: The key register (0x61) reads back the value written and reads 0 after any start request, whether it was accepted or refused.
- R9: Status bit2 stays set through unrelated writes and clears only when 1 is written to 0x62 bit2.
- R10: While busy (loading or programming), writes to 0x20..0x2B and start requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_re_i |
| supply_ok_i | input | 1 | Supply high enough for programming |
| wake_i | input | 1 | Wake pulse, requests reload of the image |
| nv_req_o | output | 1 | Array access request |
| nv_we_o | output | 1 | Array access is a write |
| nv_addr_o | output | IDX_W | Array byte index |
| nv_wdata_o | output | DATA_W | Array write data |
| nv_rdata_i | input | DATA_W | Array read data, the cycle after an accepted read |
| nv_busy_i | input | 1 | Array busy, access not accepted |

## Verification
Two functions can fall in the same cycle. One is the sequencer writing a loaded byte into a configuration register. The other is a host write that targets the same register bank. The bench provokes this by sending a host write to 0x2B in the cycle right after a wake pulse starts a reload, and by sending a write to 0x20 during programming. It judges the outcome by reading the registers back once the block is idle: they must hold the array image, not the host's value. A start request is also placed right after refused attempts to show that the key clear and the sticky error flag combine correctly.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_CAP,
    ST_WR_REQ,
    ST_SETTLE
  } seq_state_e;

  localparam int unsigned CMD_START_BIT = 0;
  localparam int unsigned CMD_BUSY_BIT  = 1;
  localparam int unsigned CMD_ERR_BIT   = 2;
  localparam int unsigned CTL_SEL_BIT   = 0;
endpackage

// File: rtl/nvm_cfg_regs.sv
module nvm_cfg_regs #(
  parameter int unsigned N     = 12,
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [W-1:0]     ld_data_i,
  output logic [N*W-1:0]   cfg_o
);
  for (genvar g = 0; g < N; g++) begin : g_byte
    logic [W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (ld_we_i && ld_idx_i == IDX_W'(g)) byte_q <= ld_data_i;
      else if (wr_en_i && wr_idx_i == IDX_W'(g)) byte_q <= wr_data_i;
    end
    assign cfg_o[g*W +: W] = byte_q;
  end
endmodule

// File: rtl/nvm_key_gate.sv
module nvm_key_gate #(
  parameter int unsigned   W   = 8,
  parameter logic [W-1:0]  KEY = 8'hB6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         key_we_i,
  input  logic [W-1:0] key_wdata_i,
  input  logic         start_req_i,
  input  logic         host_sel_i,
  input  logic         supply_ok_i,
  input  logic         err_clr_i,
  output logic [W-1:0] key_o,
  output logic         accept_o,
  output logic         reject_o,
  output logic         err_o
);
  logic [W-1:0] key_q;
  logic         err_q;

  assign accept_o = start_req_i && (key_q == KEY) && host_sel_i && supply_ok_i;
  assign reject_o = start_req_i && !accept_o;

  // every attempt burns the key
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          key_q <= '0;
    else if (start_req_i) key_q <= '0;
    else if (key_we_i)    key_q <= key_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (reject_o)  err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign key_o = key_q;
  assign err_o = err_q;
endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
  import nvm_seq_pkg::*;
#(
  parameter int unsigned N          = 12,
  parameter int unsigned W          = 8,
  parameter int unsigned PROG_TICKS = 2400000,
  parameter int unsigned IDX_W      = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_req_i,
  input  logic             prog_go_i,
  input  logic             nv_busy_i,
  input  logic [W-1:0]     nv_rdata_i,
  input  logic [N*W-1:0]   cfg_i,
  output logic             nv_req_o,
  output logic             nv_we_o,
  output logic [IDX_W-1:0] nv_addr_o,
  output logic [W-1:0]     nv_wdata_o,
  output logic             ld_we_o,
  output logic [IDX_W-1:0] ld_idx_o,
  output logic [W-1:0]     ld_data_o,
  output logic             busy_o,
  output logic             prog_o
);
  localparam int unsigned CNT_W = (PROG_TICKS > 1) ? $clog2(PROG_TICKS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_TICKS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  // reset lands in the read phase so the image loads at power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RD_REQ;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (prog_go_i)       state_q <= ST_WR_REQ;
          else if (load_req_i) state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: if (!nv_busy_i) state_q <= ST_RD_CAP;
        ST_RD_CAP: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            state_q <= ST_RD_REQ;
            idx_q   <= idx_q + 1'b1;
          end
        end
        ST_WR_REQ: begin
          if (!nv_busy_i) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_SETTLE;
              cnt_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (cnt_q == LAST_CNT) state_q <= ST_IDLE;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign nv_req_o   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign nv_we_o    = (state_q == ST_WR_REQ);
  assign nv_addr_o  = idx_q;
  assign nv_wdata_o = cfg_i[idx_q*W +: W];
  assign ld_we_o    = (state_q == ST_RD_CAP);
  assign ld_idx_o   = idx_q;
  assign ld_data_o  = nv_rdata_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign prog_o     = (state_q == ST_WR_REQ) || (state_q == ST_SETTLE);
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_seq_pkg::*;
#(
  parameter int unsigned        CFG_BYTES  = 12,
  parameter int unsigned        DATA_W     = 8,
  parameter int unsigned        ADDR_W     = 8,
  parameter int unsigned        IDX_W      = $clog2(CFG_BYTES),
  parameter logic [ADDR_W-1:0]  CFG_BASE   = 'h20,
  parameter logic [ADDR_W-1:0]  CTL_ADDR   = 'h60,
  parameter logic [ADDR_W-1:0]  KEY_ADDR   = 'h61,
  parameter logic [ADDR_W-1:0]  CMD_ADDR   = 'h62,
  parameter logic [DATA_W-1:0]  UNLOCK_KEY = 'hB6,
  parameter int unsigned        PROG_TICKS = 2400000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_rvalid_o,
  input  logic              supply_ok_i,
  input  logic              wake_i,
  output logic              nv_req_o,
  output logic              nv_we_o,
  output logic [IDX_W-1:0]  nv_addr_o,
  output logic [DATA_W-1:0] nv_wdata_o,
  input  logic [DATA_W-1:0] nv_rdata_i,
  input  logic              nv_busy_i
);
  localparam logic [ADDR_W-1:0] CFG_LAST = ADDR_W'(CFG_BASE + CFG_BYTES - 1);

  logic                      in_cfg;
  logic [IDX_W-1:0]          cfg_idx;
  logic [CFG_BYTES*DATA_W-1:0] cfg_flat;
  logic                      seq_busy, prog_act;
  logic                      ld_we;
  logic [IDX_W-1:0]          ld_idx;
  logic [DATA_W-1:0]         ld_data;
  logic                      host_sel_q;
  logic                      start_req, err_clr, key_we;
  logic                      prog_accept, prog_reject;
  logic [DATA_W-1:0]         key_q;
  logic                      err_q;
  logic [DATA_W-1:0]         rd_mux, rdata_q;
  logic                      rvalid_q;

  assign in_cfg    = (reg_addr_i >= CFG_BASE) && (reg_addr_i <= CFG_LAST);
  assign cfg_idx   = IDX_W'(reg_addr_i - CFG_BASE);
  assign key_we    = reg_we_i && (reg_addr_i == KEY_ADDR);
  assign start_req = reg_we_i && (reg_addr_i == CMD_ADDR) &&
                     reg_wdata_i[CMD_START_BIT] && !seq_busy;
  assign err_clr   = reg_we_i && (reg_addr_i == CMD_ADDR) && reg_wdata_i[CMD_ERR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_sel_q <= 1'b0;
    else if (reg_we_i && reg_addr_i == CTL_ADDR) host_sel_q <= reg_wdata_i[CTL_SEL_BIT];
  end

  nvm_cfg_regs #(.N(CFG_BYTES), .W(DATA_W), .IDX_W(IDX_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_we_i && in_cfg && !seq_busy),
    .wr_idx_i  (cfg_idx),
    .wr_data_i (reg_wdata_i),
    .ld_we_i   (ld_we),
    .ld_idx_i  (ld_idx),
    .ld_data_i (ld_data),
    .cfg_o     (cfg_flat)
  );

  nvm_key_gate #(.W(DATA_W), .KEY(UNLOCK_KEY)) i_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_we_i    (key_we),
    .key_wdata_i (reg_wdata_i),
    .start_req_i (start_req),
    .host_sel_i  (host_sel_q),
    .supply_ok_i (supply_ok_i),
    .err_clr_i   (err_clr),
    .key_o       (key_q),
    .accept_o    (prog_accept),
    .reject_o    (prog_reject),
    .err_o       (err_q)
  );

  nvm_seq_fsm #(.N(CFG_BYTES), .W(DATA_W), .PROG_TICKS(PROG_TICKS), .IDX_W(IDX_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_req_i (wake_i && !host_sel_q),
    .prog_go_i  (prog_accept),
    .nv_busy_i  (nv_busy_i),
    .nv_rdata_i (nv_rdata_i),
    .cfg_i      (cfg_flat),
    .nv_req_o   (nv_req_o),
    .nv_we_o    (nv_we_o),
    .nv_addr_o  (nv_addr_o),
    .nv_wdata_o (nv_wdata_o),
    .ld_we_o    (ld_we),
    .ld_idx_o   (ld_idx),
    .ld_data_o  (ld_data),
    .busy_o     (seq_busy),
    .prog_o     (prog_act)
  );

  always_comb begin
    rd_mux = '0;
    if (in_cfg) begin
      rd_mux = cfg_flat[cfg_idx*DATA_W +: DATA_W];
    end else if (reg_addr_i == CTL_ADDR) begin
      rd_mux[CTL_SEL_BIT] = host_sel_q;
    end else if (reg_addr_i == KEY_ADDR) begin
      rd_mux = key_q;
    end else if (reg_addr_i == CMD_ADDR) begin
      rd_mux[CMD_START_BIT] = prog_act;
      rd_mux[CMD_BUSY_BIT]  = seq_busy;
      rd_mux[CMD_ERR_BIT]   = err_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= reg_re_i;
      if (reg_re_i) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata_o  = rdata_q;
  assign reg_rvalid_o = rvalid_q;
endmodule

// File: rtl/nvm_prog_seq_chk.sv
module nvm_prog_seq_chk #(
  parameter int unsigned N = 12,
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_req,
  input logic         accept,
  input logic         reject,
  input logic [W-1:0] key,
  input logic         err,
  input logic         err_clr,
  input logic         prog,
  input logic [N*W-1:0] cfg,
  input logic         nv_req,
  input logic         nv_we
);
  p_accept_starts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> prog);

  p_key_burnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req |=> key == '0);

  p_reject_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> err);

  p_reject_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> !(nv_req && nv_we));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err && !err_clr |=> err);

  p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog |=> $stable(cfg));
endmodule

bind nvm_prog_seq nvm_prog_seq_chk #(.N(CFG_BYTES), .W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_req (start_req),
  .accept    (prog_accept),
  .reject    (prog_reject),
  .key       (key_q),
  .err       (err_q),
  .err_clr   (err_clr),
  .prog      (prog_act),
  .cfg       (cfg_flat),
  .nv_req    (nv_req_o),
  .nv_we     (nv_we_o)
);

// File: tb/test_nvm_prog_seq.sv
`timescale 1ns/1ps
module test_nvm_prog_seq;
  localparam int N = 12;
  localparam logic [7:0] CTL = 8'h60, KEY = 8'h61, CMD = 8'h62;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, supply_ok = 1'b1, wake = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic rvalid;
  logic nv_req, nv_we, nv_busy;
  logic [3:0] nv_addr;
  logic [7:0] nv_wdata, nv_rdata;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  logic [7:0] mem [N];
  int wr_cnt = 0;
  logic order_bad = 1'b0;
  logic [1:0] busy_cnt = '0;

  always #5 clk = ~clk;

  nvm_prog_seq #(.PROG_TICKS(20)) i_nvm_prog_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .supply_ok_i(supply_ok), .wake_i(wake),
    .nv_req_o(nv_req), .nv_we_o(nv_we), .nv_addr_o(nv_addr),
    .nv_wdata_o(nv_wdata), .nv_rdata_i(nv_rdata), .nv_busy_i(nv_busy)
  );

  // array model: writes make it busy for two cycles
  initial for (int i = 0; i < N; i++) mem[i] = 8'hA0 + 8'(i);
  initial nv_rdata = '0;
  assign nv_busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
    if (nv_req && !nv_busy && nv_addr < 4'(N)) begin
      if (nv_we) begin
        mem[nv_addr] <= nv_wdata;
        if (int'(nv_addr) != wr_cnt) order_bad <= 1'b1;
        wr_cnt <= wr_cnt + 1;
        busy_cnt <= 2'd2;
      end else begin
        nv_rdata <= mem[nv_addr];
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads in order
  always @(negedge clk) begin
    if (rvalid && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic read_exp(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic done = 1'b0;
    for (int n = 0; n < 2000 && !done; n++) begin
      @(negedge clk); re = 1'b1; addr = CMD;
      @(negedge clk); re = 1'b0;
      done = !rdata[1];
    end
    if (!done) check({tag, " idle timeout"}, 8'h01, 8'h00);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 power-up load in progress, then image present
    read_exp(CMD, 8'h02, "R1 busy during power-up load");
    wait_idle("R1");
    for (int i = 0; i < N; i++) read_exp(8'h20 + 8'(i), 8'hA0 + 8'(i), "R1 loaded byte");

    // R3 host write
    reg_wr(8'h25, 8'h5A);
    read_exp(8'h25, 8'h5A, "R3 host write readback");

    // R6 select bit clear -> refused; R8 key cleared
    reg_wr(KEY, 8'hB6);
    read_exp(KEY, 8'hB6, "R8 key readback");
    reg_wr(CMD, 8'h01);
    read_exp(CMD, 8'h04, "R6 refused without select bit");
    read_exp(KEY, 8'h00, "R8 key cleared after refusal");
    check("R6 no array write", 8'(wr_cnt), 8'h00);

    // R9 sticky then cleared
    reg_wr(CTL, 8'h01);
    read_exp(CMD, 8'h04, "R9 error survives unrelated write");
    reg_wr(CMD, 8'h04);
    read_exp(CMD, 8'h00, "R9 error cleared by write-one");

    // R7 supply low
    supply_ok = 1'b0;
    reg_wr(KEY, 8'hB6);
    reg_wr(CMD, 8'h01);
    read_exp(CMD, 8'h04, "R7 refused with supply low");
    read_exp(KEY, 8'h00, "R8 key cleared after supply refusal");
    check("R7 no array write", 8'(wr_cnt), 8'h00);
    supply_ok = 1'b1;
    reg_wr(CMD, 8'h04);

    // R6 wrong key
    reg_wr(KEY, 8'h12);
    reg_wr(CMD, 8'h01);
    read_exp(CMD, 8'h04, "R6 refused with wrong key");
    reg_wr(CMD, 8'h04);

    // R4/R5 accepted programming; R10 write blocked while programming
    for (int i = 0; i < N; i++) reg_wr(8'h20 + 8'(i), 8'h30 + 8'(i));
    reg_wr(KEY, 8'hB6);
    reg_wr(CMD, 8'h01);
    read_exp(CMD, 8'h03, "R5 start and busy read 1 while programming");
    reg_wr(8'h20, 8'hEE);
    reg_wr(CMD, 8'h01);
    wait_idle("R5");
    read_exp(CMD, 8'h00, "R5 start self-cleared");
    read_exp(8'h20, 8'h30, "R10 write during programming ignored");
    read_exp(KEY, 8'h00, "R8 key cleared after accepted start");
    check("R4 byte count", 8'(wr_cnt), 8'(N));
    check("R4 ascending order", {7'b0, order_bad}, 8'h00);
    for (int i = 0; i < N; i++) check("R4 stored byte", mem[i], 8'h30 + 8'(i));

    // R2 wake with host ownership keeps host values
    reg_wr(8'h21, 8'h77);
    pulse_wake();
    read_exp(CMD, 8'h00, "R2 wake with select bit set starts no load");
    read_exp(8'h21, 8'h77, "R2 host value kept");

    // R2 wake reload; R10 host write collides with the loader
    reg_wr(CTL, 8'h00);
    pulse_wake();
    reg_wr(8'h2B, 8'hEE);
    wait_idle("R2");
    read_exp(8'h21, 8'h31, "R2 reload restored image");
    read_exp(8'h2B, 8'h3B, "R10 write during reload ignored");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule